// File: doc/BRIEF.md
# Operand Effective Address Unit

The unit resolves one source operand for a simple register-memory processor. It receives a 3-bit addressing-mode code, a constant taken from the instruction, the register file contents, a register selector and the current program counter. It returns the operand value. For the memory-based modes it also returns the effective address from which that value was read.

When `start_i` is accepted, the unit does one of two things. For immediate and illegal codes it finishes on the next cycle. For the memory modes it drives a single-port synchronous read port, with one or two chained reads, and finishes one cycle after the last read returns. As a result the latency depends on the mode: 1, 3 or 5 cycles.

The unit flags an unused mode code with an illegal indication. All address arithmetic is modulo 2^16 and wraps without any report.

Top module: `opnd_resolve`

## Requirements
- R1: Mode code 0 (immediate) returns `const_i` as the operand and `eaddr_o` = 0. It issues no read and pulses `done_o` in the cycle after the start cycle.
- R2: Mode code 1 (direct) issues one read at `const_i`. The operand is the word read, `eaddr_o` is `const_i`, and `done_o` pulses 3 cycles after the start cycle.
- R3: Mode code 2 (register indirect) reads at the register selected by `reg_sel_i` and ignores `const_i`. It has one read and a latency of 3.
- R4: Mode code 3 (memory indirect) reads at `const_i` and then reads at the word returned by the first read. The operand is the second word and `eaddr_o` is the second address. It has two reads and a latency of 5. A pointer value of 0 is a valid address.
- R5: Mode code 4 (indexed) reads at `const_i` + the register selected by `reg_sel_i`, modulo 2^16. It has one read and a latency of 3.
- R6: Mode code 5 (PC-relative) reads at `const_i` + `pc_i`, modulo 2^16. It has one read and a latency of 3.
- R7: Mode codes 6 and 7 pulse `done_o` and `illegal_o` together in the cycle after the start cycle, with operand 0 and `eaddr_o` 0. No read is issued. `illegal_o` is never high without `done_o`.
- R8: `mem_req_o` is a single-cycle strobe that is never high in two consecutive cycles. The read data is taken from `mem_rdata_i` in the cycle after the strobe.
- R9: `done_o` is a one-cycle pulse. `operand_o` and `eaddr_o` hold their values until the next accepted start.
- R10: `start_i` is ignored while an operation is in progress.
- R11: After reset, `done_o`, `mem_req_o`, `illegal_o`, `operand_o` and `eaddr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin resolving an operand; sampled only when idle |
| mode_i | input | 3 | Addressing-mode code |
| const_i | input | 16 | Instruction constant field |
| reg_sel_i | input | 3 | Register used as the pointer or the index |
| regs_i | input | 128 | Register file contents; register k is at bits k*16 and up |
| pc_i | input | 16 | Current program counter |
| mem_req_o | output | 1 | Read strobe |
| mem_addr_o | output | 16 | Read address |
| mem_rdata_i | input | 16 | Read data, valid the cycle after the strobe |
| done_o | output | 1 | Result valid pulse |
| illegal_o | output | 1 | Unused mode code, pulsed with `done_o` |
| operand_o | output | 16 | Resolved operand |
| eaddr_o | output | 16 | Effective address (0 for non-memory modes) |

## Verification
The bound assertions check the following on every cycle:
- the single-cycle immediate and illegal completion, with the value that goes with it;
- the direct-mode request address;
- the spacing of read strobes;
- the pulse shape of `done_o`.

Only the bench scenarios can show the rest, because they need a model of memory contents:
- that the operand actually matches the memory word for each mode;
- that the memory-indirect chain follows a pointer to address 0;
- that indexed and PC-relative addresses wrap;
- that a start pulse during an operation leaves the result intact.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int unsigned MODE_W = 3;

  localparam logic [MODE_W-1:0] MD_IMM   = 3'd0;
  localparam logic [MODE_W-1:0] MD_DIR   = 3'd1;
  localparam logic [MODE_W-1:0] MD_RIND  = 3'd2;
  localparam logic [MODE_W-1:0] MD_MIND  = 3'd3;
  localparam logic [MODE_W-1:0] MD_IDX   = 3'd4;
  localparam logic [MODE_W-1:0] MD_PCREL = 3'd5;

  typedef enum logic [1:0] {BASE_ZERO, BASE_REG, BASE_PC} base_e;

  typedef struct packed {
    logic  use_mem;
    logic  chain;
    logic  illegal;
    logic  use_const;
    base_e base;
  } mode_ctl_t;

  typedef enum logic [2:0] {S_IDLE, S_REQ1, S_DAT1, S_REQ2, S_DAT2} seq_e;
endpackage

// File: rtl/opnd_mode_dec.sv
module opnd_mode_dec
  import opnd_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output mode_ctl_t         ctl_o
);
  always_comb begin
    ctl_o = '{use_mem: 1'b0, chain: 1'b0, illegal: 1'b0, use_const: 1'b1, base: BASE_ZERO};
    unique case (mode_i)
      MD_IMM:   ;
      MD_DIR:   ctl_o.use_mem = 1'b1;
      MD_RIND:  begin ctl_o.use_mem = 1'b1; ctl_o.use_const = 1'b0; ctl_o.base = BASE_REG; end
      MD_MIND:  begin ctl_o.use_mem = 1'b1; ctl_o.chain = 1'b1; end
      MD_IDX:   begin ctl_o.use_mem = 1'b1; ctl_o.base = BASE_REG; end
      MD_PCREL: begin ctl_o.use_mem = 1'b1; ctl_o.base = BASE_PC; end
      default:  ctl_o.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import opnd_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned NREG   = 8,
  localparam int unsigned SEL_W = $clog2(NREG)
) (
  input  base_e                  base_i,
  input  logic                   use_const_i,
  input  logic [WORD_W-1:0]      const_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic [NREG*WORD_W-1:0] regs_i,
  input  logic [WORD_W-1:0]      pc_i,
  output logic [WORD_W-1:0]      ea_o
);
  logic [WORD_W-1:0] base_val, off_val;

  always_comb begin
    unique case (base_i)
      BASE_REG: base_val = regs_i[sel_i*WORD_W +: WORD_W];
      BASE_PC:  base_val = pc_i;
      default:  base_val = '0;
    endcase
    off_val = use_const_i ? const_i : '0;
  end

  // modulo 2^WORD_W, carry dropped
  assign ea_o = base_val + off_val;
endmodule

// File: rtl/opnd_resolve.sv
module opnd_resolve
  import opnd_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned NREG   = 8,
  localparam int unsigned SEL_W = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [MODE_W-1:0]      mode_i,
  input  logic [WORD_W-1:0]      const_i,
  input  logic [SEL_W-1:0]       reg_sel_i,
  input  logic [NREG*WORD_W-1:0] regs_i,
  input  logic [WORD_W-1:0]      pc_i,
  output logic                   mem_req_o,
  output logic [WORD_W-1:0]      mem_addr_o,
  input  logic [WORD_W-1:0]      mem_rdata_i,
  output logic                   done_o,
  output logic                   illegal_o,
  output logic [WORD_W-1:0]      operand_o,
  output logic [WORD_W-1:0]      eaddr_o
);
  mode_ctl_t         ctl;
  logic [WORD_W-1:0] ea;
  seq_e              st_q;
  logic              chain_q, req_q, done_q, ill_q;
  logic [WORD_W-1:0] addr_q, opnd_q, ea_q;

  opnd_mode_dec u_dec (.mode_i(mode_i), .ctl_o(ctl));

  opnd_addr_gen #(.WORD_W(WORD_W), .NREG(NREG)) u_agen (
    .base_i(ctl.base), .use_const_i(ctl.use_const), .const_i(const_i),
    .sel_i(reg_sel_i), .regs_i(regs_i), .pc_i(pc_i), .ea_o(ea)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      chain_q <= 1'b0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
      addr_q  <= '0;
      opnd_q  <= '0;
      ea_q    <= '0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          if (ctl.illegal) begin
            done_q <= 1'b1;
            ill_q  <= 1'b1;
            opnd_q <= '0;
            ea_q   <= '0;
          end else if (!ctl.use_mem) begin
            done_q <= 1'b1;
            opnd_q <= const_i;
            ea_q   <= '0;
          end else begin
            req_q   <= 1'b1;
            addr_q  <= ea;
            ea_q    <= ea;
            chain_q <= ctl.chain;
            st_q    <= S_REQ1;
          end
        end
        S_REQ1: st_q <= S_DAT1;
        S_DAT1: begin
          if (chain_q) begin
            // returned word is the pointer for the second read
            req_q  <= 1'b1;
            addr_q <= mem_rdata_i;
            ea_q   <= mem_rdata_i;
            st_q   <= S_REQ2;
          end else begin
            opnd_q <= mem_rdata_i;
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end
        end
        S_REQ2: st_q <= S_DAT2;
        S_DAT2: begin
          opnd_q <= mem_rdata_i;
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o  = req_q;
  assign mem_addr_o = addr_q;
  assign done_o     = done_q;
  assign illegal_o  = ill_q;
  assign operand_o  = opnd_q;
  assign eaddr_o    = ea_q;
endmodule

// File: rtl/opnd_resolve_chk.sv
module opnd_resolve_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [2:0]        mode_i,
  input logic [WORD_W-1:0] const_i,
  input logic              busy_i,
  input logic              mem_req_o,
  input logic [WORD_W-1:0] mem_addr_o,
  input logic              done_o,
  input logic              illegal_o,
  input logic [WORD_W-1:0] operand_o
);
  AST_IMM_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && mode_i == 3'd0) |=> (done_o && !mem_req_o && operand_o == $past(const_i))); // R1

  AST_DIR_REQ_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && mode_i == 3'd1) |=> (mem_req_o && mem_addr_o == $past(const_i))); // R2

  AST_BAD_MODE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && mode_i[2:1] == 2'b11) |=> (done_o && illegal_o && !mem_req_o && operand_o == '0)); // R7

  AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (done_o && operand_o == '0)); // R7

  AST_REQ_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (!mem_req_o && !done_o)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !start_i && !busy_i) |=> $stable(operand_o)); // R9
endmodule

bind opnd_resolve opnd_resolve_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
  .const_i(const_i), .busy_i(st_q != opnd_pkg::S_IDLE), .mem_req_o(mem_req_o),
  .mem_addr_o(mem_addr_o), .done_o(done_o), .illegal_o(illegal_o), .operand_o(operand_o)
);

// File: tb/opnd_resolve_tb.sv
module opnd_resolve_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   mode = '0;
  logic [15:0]  cst = '0;
  logic [2:0]   sel = '0;
  logic [127:0] regs = '0;
  logic [15:0]  pc = '0;
  logic         mem_req, done, illegal;
  logic [15:0]  mem_addr, rdata = '0, operand, eaddr;

  logic [15:0]  mem [0:65535];
  int           nreq = 0;
  logic [15:0]  last_addr = '0;
  int           n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  opnd_resolve u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .const_i(cst),
    .reg_sel_i(sel), .regs_i(regs), .pc_i(pc), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rdata_i(rdata), .done_o(done),
    .illegal_o(illegal), .operand_o(operand), .eaddr_o(eaddr)
  );

  // R8: synchronous read, data the cycle after the strobe
  always @(posedge clk) begin
    if (mem_req) begin
      rdata     <= mem[mem_addr];
      last_addr <= mem_addr;
      nreq      = nreq + 1;
    end
  end

  function automatic logic [15:0] reg_val(input int k);
    return (k == 5) ? 16'hFFF8 : 16'h1000 * k[15:0] + 16'h0033;
  endfunction

  function automatic logic [15:0] mem_val(input int a);
    logic [15:0] w = a[15:0];
    return {w[7:0], w[15:8]} ^ 16'h3C5A;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 20000", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  md;
    logic [15:0] c;
    logic [2:0]  s;
    logic [15:0] p;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 16'h1234, 3'd0, 16'h0000},
    '{3'd1, 16'h0042, 3'd0, 16'h0000},
    '{3'd2, 16'h7777, 3'd3, 16'h0000},
    '{3'd3, 16'h0400, 3'd0, 16'h0000},
    '{3'd4, 16'h0010, 3'd2, 16'h0000},
    '{3'd5, 16'h0100, 3'd0, 16'h2000},
    '{3'd6, 16'h5555, 3'd1, 16'h0000},
    '{3'd7, 16'hAAAA, 3'd1, 16'h1111},
    '{3'd4, 16'h0020, 3'd5, 16'h0000},
    '{3'd5, 16'h0030, 3'd0, 16'hFFF0}
  };

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  // start for one cycle, then count cycles until done
  task automatic launch(input vec_t v, output int lat);
    @(negedge clk);
    mode = v.md; cst = v.c; sel = v.s; pc = v.p;
    nreq = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_vec(input vec_t v);
    int          lat, e_lat, e_req;
    logic [15:0] e_op, e_ea;
    logic        e_ill;
    string       t;
    t     = tag_of(v.md);
    e_ill = 1'b0; e_ea = '0; e_op = '0; e_req = 1; e_lat = 3;
    case (v.md)
      3'd0: begin e_op = v.c; e_req = 0; e_lat = 1; end
      3'd1: e_ea = v.c;
      3'd2: e_ea = reg_val(int'(v.s));
      3'd3: begin e_ea = mem[v.c]; e_req = 2; e_lat = 5; end
      3'd4: e_ea = v.c + reg_val(int'(v.s));
      3'd5: e_ea = v.c + v.p;
      default: begin e_ill = 1'b1; e_req = 0; e_lat = 1; end
    endcase
    if (e_req != 0) e_op = mem[e_ea];
    launch(v, lat);
    chk(t, "latency", lat, e_lat);
    chk(t, "operand", operand, e_op);
    chk(t, "eaddr", eaddr, e_ea);
    chk(t, "illegal", illegal, e_ill);
    chk(t, "read count", nreq, e_req);
    if (e_req != 0) chk(t, "last read addr", last_addr, e_ea);
  endtask

  initial begin
    int lat;
    for (int a = 0; a < 65536; a++) mem[a] = mem_val(a);
    mem[16'h0300] = 16'h0000;  // pointer to address 0
    mem[16'h0000] = 16'hBEEF;
    for (int k = 0; k < 8; k++) regs[k*16 +: 16] = reg_val(k);

    // R11: reset state
    #35;
    chk("R11", "done", done, 0);
    chk("R11", "mem_req", mem_req, 0);
    chk("R11", "illegal", illegal, 0);
    chk("R11", "operand", operand, 0);
    chk("R11", "eaddr", eaddr, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R4: pointer at 0x0300 holds 0, second read at address 0
    run_vec('{3'd3, 16'h0300, 3'd0, 16'h0000});
    chk("R4", "pointer-to-zero operand", operand, 16'hBEEF);

    // R9: done low and result held with no new start
    @(negedge clk);
    chk("R9", "done pulse width", done, 0);
    repeat (3) @(negedge clk);
    chk("R9", "operand hold", operand, 16'hBEEF);
    chk("R9", "eaddr hold", eaddr, 16'h0000);

    // R10: start during a memory-indirect operation is ignored
    @(negedge clk);
    mode = 3'd3; cst = 16'h0300; nreq = 0;
    start = 1'b1;
    @(negedge clk);
    mode = 3'd0; cst = 16'hDEAD;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk("R10", "latency", lat, 5);
    chk("R10", "operand", operand, 16'hBEEF);
    chk("R10", "read count", nreq, 2);
    @(negedge clk);
    chk("R10", "no extra done", done, 0);

    // R11: asynchronous reset clears a finished result
    rst_n = 1'b0;
    #5;
    chk("R11", "operand after reset", operand, 0);
    chk("R11", "eaddr after reset", eaddr, 0);
    summary();
  end
endmodule